// File: doc/BRIEF.md
# Self-Timed Parallel Nonvolatile Memory Access Sequencer

This block sits on the host side of an asynchronous, SRAM-like byte-wide nonvolatile memory. The memory programs itself once a byte has been written. A client issues one request at a time through a valid/ready handshake, carrying a direction flag, an address and a write byte. The sequencer produces the active-low chip-enable, output-enable and write-enable strobes and drives the address and write-data buses. It spaces every edge by clock-count parameters, which are nanosecond minimums rounded up to whole cycles at the design clock. It reports completion with a one-cycle `done` pulse, and with a one-cycle `err` pulse when a programming cycle does not finish in time.

After the write pulse the block has to find out when the memory's internal programming cycle has ended. It does not wait a fixed worst-case time. A configuration input selects one of two methods. The first watches the open-drain ready/busy line through a parameterised synchroniser. The second repeats reads of the written location until the top data bit matches the value written, since the memory returns that bit inverted while it is still busy. Both methods share a programmable timeout. Plain reads hold both enables low for a programmable number of cycles and then capture the data bus.

Top module: `eeprom_wr_seq`

## Requirements
- R1: While idle and after reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, `req_ready` is 1, and `done` and `err` are 0.
- R2: A write drives `mem_we_n` low for exactly `T_WP` cycles (default 10), with `mem_ce_n` low and `mem_oe_n` high throughout.
- R3: `mem_ce_n` goes low with address and data driven (`mem_dout_en`=1) and `mem_oe_n` high exactly `T_SU` cycles (default 1) before `mem_we_n` falls. Address, data, `mem_dout_en`=1, `mem_oe_n`=1 and `mem_ce_n`=0 all persist for `T_HLD` cycles (default 1) after `mem_we_n` rises. `mem_addr` does not change while `mem_ce_n` is low.
- R4: With `cfg_poll`=0, the block ignores `mem_rdy` for `T_DB`+`RDY_SYNC` cycles after the hold phase. It then pulses `done` exactly `RDY_SYNC`+1 cycles (default 3) after `mem_rdy` rises to 1 (1 = ready).
- R5: With `cfg_poll`=1, end of write is found by reads that hold `mem_ce_n`/`mem_oe_n` low for `T_ACC` cycles (default 15) and then compare `mem_din[DW-1]` (bit 7) with bit 7 of the written byte. On a mismatch the enables are released for `T_GAP` cycles and the read is retried. `done` never comes before the memory has finished programming.
- R6: If end of write is not seen, `err` pulses `T_HLD`+`cfg_timeout`+1 cycles after `mem_we_n` rises, and no `done` is given for that request. This holds in both modes.
- R7: A read (`req_write`=0) holds `mem_ce_n` and `mem_oe_n` low for W = max(`cfg_rd_wait`,1) cycles. It then captures `mem_din` into `rd_data`, and `done` rises W+1 cycles after the cycle in which the request was presented and accepted. A `cfg_rd_wait` of 0 behaves as 1.
- R8: `req_ready` is 0 from the cycle after acceptance until the cycle in which `done` or `err` is 1, and it is 1 again in that cycle.
- R9: The byte on `req_wdata` is the value present on `mem_dout` when `mem_we_n` rises, at `req_addr`, so a later read returns it.
- R10: `done` and `err` are single-cycle pulses and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = byte write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Byte to write |
| cfg_poll | input | 1 | End-of-write method: 0 ready/busy line, 1 top-bit polling |
| cfg_timeout | input | TOW | End-of-write timeout in cycles |
| cfg_rd_wait | input | TW | Read access wait in cycles (0 acts as 1) |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | End of write not seen in time (one cycle) |
| rd_data | output | DW | Data captured by the last read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address bus |
| mem_dout | output | DW | Write data toward memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DW | Data bus from memory |
| mem_rdy | input | 1 | Ready/busy line, 1 = ready |

## Verification
A read's `done` is due exactly W+1 cycles after the request cycle. A busy-line write's `done` is due `RDY_SYNC`+1 cycles after the memory model raises ready, and a timeout's `err` is due `T_HLD`+`cfg_timeout`+1 cycles after the write strobe rises. The bench keeps a cycle counter, samples every port on the falling clock edge, records the counter value at each of those reference events, and compares the differences with these formulas. Polling writes have no single due cycle. For them the bench checks that `done` arrives after the model's busy period ends and no later than two poll rounds past it. Strobe spacing is measured on every write by counting falling-edge samples of each enable.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_SETTLE,
      ST_MONITOR,
      ST_PREAD,
      ST_PGAP,
      ST_READ
   } seq_state_e;

   function automatic logic is_eow(input seq_state_e s);
      return (s == ST_SETTLE) || (s == ST_MONITOR) || (s == ST_PREAD) || (s == ST_PGAP);
   endfunction
endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/seq_timeout.sv
module seq_timeout #(
   parameter int TOW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           en,
   input  logic [TOW-1:0] limit,
   output logic           hit
);
   logic [TOW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (en && cnt_q != limit)  cnt_q <= cnt_q + 1'b1;
   end

   assign hit = en && (cnt_q == limit);

   p_clear_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
   import eeprom_seq_pkg::*;
#(
   parameter int AW       = 11,
   parameter int DW       = 8,
   parameter int TW       = 8,
   parameter int TOW      = 16,
   parameter int T_SU     = 1,
   parameter int T_WP     = 10,
   parameter int T_WP_MAX = 100,
   parameter int T_HLD    = 1,
   parameter int T_DB     = 5,
   parameter int T_ACC    = 15,
   parameter int T_GAP    = 1,
   parameter int RDY_SYNC = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic           req_write,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   input  logic           cfg_poll,
   input  logic [TOW-1:0] cfg_timeout,
   input  logic [TW-1:0]  cfg_rd_wait,
   output logic           done,
   output logic           err,
   output logic [DW-1:0]  rd_data,
   output logic           mem_ce_n,
   output logic           mem_oe_n,
   output logic           mem_we_n,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_dout,
   output logic           mem_dout_en,
   input  logic [DW-1:0]  mem_din,
   input  logic           mem_rdy
);
   localparam int T_SETTLE = T_DB + RDY_SYNC;
   localparam int PBIT     = DW - 1;
   localparam int TMAX     = (1 << TW) - 1;

   if (T_SU < 1 || T_HLD < 1 || T_GAP < 1 || T_ACC < 1 || T_SETTLE < 1)
      $error("phase lengths must be at least one cycle");
   if (T_WP < 1 || T_WP > T_WP_MAX)
      $error("write pulse outside allowed range");
   if (T_WP > TMAX || T_ACC > TMAX || T_SETTLE > TMAX || T_SU > TMAX || T_HLD > TMAX)
      $error("timer width TW too small for phase lengths");
   if (RDY_SYNC < 0 || RDY_SYNC > 4)
      $error("RDY_SYNC must be 0 to 4");

   // ready/busy synchroniser, depth chosen by parameter
   logic rdy_s;
   if (RDY_SYNC == 0) begin : g_nosync
      assign rdy_s = mem_rdy;
   end else begin : g_sync
      logic [RDY_SYNC-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;
         else        sh_q <= {sh_q[RDY_SYNC-2 >= 0 ? RDY_SYNC-2 : 0 : 0], mem_rdy} & {RDY_SYNC{1'b1}};
      end
      assign rdy_s = sh_q[RDY_SYNC-1];
   end

   seq_state_e    st_q, st_d;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q, rdat_q;
   logic          wr_q, done_q, err_q;
   logic          done_d, err_d, cap_rd;
   logic          tmr_load, tmr_exp, to_hit;
   logic [TW-1:0] tmr_val, rd_len;
   logic          accept, poll_ok;

   assign accept  = req_valid && (st_q == ST_IDLE);
   assign rd_len  = (cfg_rd_wait == '0) ? TW'(1) : cfg_rd_wait;
   assign poll_ok = (mem_din[PBIT] == data_q[PBIT]);

   seq_phase_timer #(.TW(TW)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp));

   seq_timeout #(.TOW(TOW)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(st_q == ST_WHOLD), .en(is_eow(st_q)),
      .limit(cfg_timeout), .hit(to_hit));

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      done_d   = 1'b0;
      err_d    = 1'b0;
      cap_rd   = 1'b0;
      unique case (st_q)
         ST_IDLE: if (req_valid) begin
            tmr_load = 1'b1;
            if (req_write) begin st_d = ST_WSETUP; tmr_val = TW'(T_SU - 1); end
            else           begin st_d = ST_READ;   tmr_val = rd_len - 1'b1; end
         end
         ST_WSETUP: if (tmr_exp) begin
            st_d = ST_WPULSE; tmr_load = 1'b1; tmr_val = TW'(T_WP - 1);
         end
         ST_WPULSE: if (tmr_exp) begin
            st_d = ST_WHOLD; tmr_load = 1'b1; tmr_val = TW'(T_HLD - 1);
         end
         ST_WHOLD: if (tmr_exp) begin
            st_d = ST_SETTLE; tmr_load = 1'b1; tmr_val = TW'(T_SETTLE - 1);
         end
         ST_SETTLE: begin
            if (to_hit) begin st_d = ST_IDLE; err_d = 1'b1; end
            else if (tmr_exp) begin
               if (cfg_poll) begin st_d = ST_PREAD; tmr_load = 1'b1; tmr_val = TW'(T_ACC - 1); end
               else                st_d = ST_MONITOR;
            end
         end
         ST_MONITOR: begin
            if (rdy_s)       begin st_d = ST_IDLE; done_d = 1'b1; end
            else if (to_hit) begin st_d = ST_IDLE; err_d  = 1'b1; end
         end
         ST_PREAD: begin
            if (tmr_exp && poll_ok) begin st_d = ST_IDLE; done_d = 1'b1; end
            else if (to_hit)        begin st_d = ST_IDLE; err_d  = 1'b1; end
            else if (tmr_exp) begin
               st_d = ST_PGAP; tmr_load = 1'b1; tmr_val = TW'(T_GAP - 1);
            end
         end
         ST_PGAP: begin
            if (to_hit) begin st_d = ST_IDLE; err_d = 1'b1; end
            else if (tmr_exp) begin
               st_d = ST_PREAD; tmr_load = 1'b1; tmr_val = TW'(T_ACC - 1);
            end
         end
         ST_READ: if (tmr_exp) begin
            st_d = ST_IDLE; done_d = 1'b1; cap_rd = 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         data_q <= '0;
         rdat_q <= '0;
         wr_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= done_d;
         err_q  <= err_d;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            wr_q   <= req_write;
         end
         if (cap_rd) rdat_q <= mem_din;
      end
   end

   assign req_ready   = (st_q == ST_IDLE);
   assign done        = done_q;
   assign err         = err_q;
   assign rd_data     = rdat_q;
   assign mem_addr    = addr_q;
   assign mem_dout    = data_q;
   assign mem_dout_en = (st_q == ST_WSETUP) || (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
   assign mem_we_n    = !(st_q == ST_WPULSE);
   assign mem_oe_n    = !((st_q == ST_PREAD) || (st_q == ST_READ));
   assign mem_ce_n    = !(mem_dout_en || !mem_oe_n);

   // write-enable low-time measured independently of the state decode
   logic [TW-1:0] we_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_len_q <= '0;
      else if (!mem_we_n) we_len_q <= we_len_q + 1'b1;
      else                we_len_q <= '0;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en));
   p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_len_q == TW'(T_WP)));
   p_write_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dout_en && !mem_ce_n && $stable(mem_dout)));
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
   p_one_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));
   p_single_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_write_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && wr_q) |-> $past(is_eow(st_q)));
endmodule

// File: tb/eeprom_wr_seq_test.sv
module eeprom_wr_seq_test;
   localparam int AW = 11, DW = 8, TW = 8, TOW = 16;
   localparam int T_SU = 1, T_WP = 10, T_HLD = 1, T_DB = 5, T_ACC = 15, T_GAP = 1, RDY_SYNC = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, cfg_poll = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [TOW-1:0] cfg_timeout = 16'd4000;
   logic [TW-1:0] cfg_rd_wait = 8'd15;
   logic req_ready, done, err, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
   logic [DW-1:0] rd_data, mem_dout;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_din = '0;
   logic mem_rdy = 1'b1;

   eeprom_wr_seq uut (.*);

   always #5 clk = ~clk;

   int cyc = 0, checks = 0, fails = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // memory model, evaluated on the falling edge
   logic [7:0] mem [0:2047];
   bit busy = 0, stuck = 0, we_prev = 1, ce_prev = 1;
   int busy_left = 0, busy_len = 30, oe_cnt = 0, ce_cnt = 0, we_lo = 0;
   int rdy_rise_cyc = 0, we_rise_cyc = 0;
   logic [AW-1:0] busy_addr = '0;

   always @(negedge clk) begin
      logic [7:0] v;
      oe_cnt = (!mem_ce_n && !mem_oe_n) ? oe_cnt + 1 : 0;
      ce_cnt = !mem_ce_n ? ce_cnt + 1 : 0;
      if (rst_n) begin
         if (we_prev && !mem_we_n) begin
            chk(ce_cnt == T_SU + 1, "R3 setup cycles", ce_cnt, T_SU + 1);
            chk(mem_oe_n && mem_dout_en, "R2 oe high / data driven at we fall", mem_oe_n, 1);
         end
         if (!mem_we_n) we_lo++;
         if (!we_prev && mem_we_n) begin
            chk(we_lo == T_WP, "R2 we low width", we_lo, T_WP);
            chk(mem_dout_en && mem_oe_n && !mem_ce_n && mem_addr == busy_addr,
                "R3 hold after we rise", mem_dout_en, 1);
            we_lo = 0;
            we_rise_cyc = cyc;
         end
      end
      if (!mem_we_n) busy_addr = mem_addr;
      if (!we_prev && mem_we_n && !mem_ce_n) begin
         mem[mem_addr] = mem_dout;
         busy = 1; busy_left = busy_len; busy_addr = mem_addr;
      end else if (busy && !stuck) begin
         busy_left--;
         if (busy_left <= 0) begin busy = 0; rdy_rise_cyc = cyc; end
      end
      mem_rdy = !busy;
      v = mem[mem_addr];
      if (oe_cnt >= T_ACC) begin
         if (busy && mem_addr == busy_addr) v[7] = ~v[7];
      end else v = ~v;
      mem_din = v;
      we_prev = mem_we_n;
      ce_prev = mem_ce_n;
   end

   logic [7:0] shadow [0:2047];

   task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                         output bit gd, output bit ge, output logic [7:0] rdat, output int fin);
      int t0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      t0 = cyc;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R8 ready low after accept", req_ready, 0);
      while (!done && !err) begin
         @(negedge clk);
         if (!done && !err && req_ready) chk(0, "R8 ready early", 1, 0);
      end
      gd = done; ge = err; rdat = rd_data; fin = cyc;
      chk(req_ready, "R8 ready back with done/err", req_ready, 1);
      chk(!(done && err), "R10 done and err exclusive", done, 0);
      @(negedge clk);
      chk(!done && !err, "R10 single-cycle pulse", done, 0);
      fin = fin - t0;
   endtask

   function automatic int exp_rd_lat(input logic [TW-1:0] w);
      return (w == 0) ? 2 : int'(w) + 1;
   endfunction

   task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input bit poll, input int blen);
      bit gd, ge; logic [7:0] r; int lat, dc;
      cfg_poll = poll; busy_len = blen;
      run_op(1'b1, a, d, gd, ge, r, lat);
      dc = cyc - 1;
      shadow[a] = d;
      chk(gd && !ge, "R4/R5 write done", gd, 1);
      if (!poll) chk(dc - rdy_rise_cyc == RDY_SYNC + 1, "R4 done latency after ready", dc - rdy_rise_cyc, RDY_SYNC + 1);
      else begin
         chk(dc > rdy_rise_cyc, "R5 no done while busy", dc, rdy_rise_cyc + 1);
         chk(dc - rdy_rise_cyc <= 2 * (T_ACC + T_GAP) + 2, "R5 done soon after ready", dc - rdy_rise_cyc, 2 * (T_ACC + T_GAP) + 2);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [TW-1:0] w, input logic [7:0] exp);
      bit gd, ge; logic [7:0] r; int lat;
      cfg_rd_wait = w;
      run_op(1'b0, a, 8'h00, gd, ge, r, lat);
      chk(gd, "R7 read done", gd, 1);
      chk(lat == exp_rd_lat(w), "R7 read latency", lat, exp_rd_lat(w));
      chk(r == exp, "R9/R7 read data", r, exp);
   endtask

   task automatic do_timeout(input bit poll, input logic [TOW-1:0] tmo);
      bit gd, ge; logic [7:0] r; int lat, ec;
      cfg_poll = poll; cfg_timeout = tmo; stuck = 1; busy_len = 10;
      run_op(1'b1, 11'h123, 8'h9C, gd, ge, r, lat);
      ec = cyc - 1;
      shadow[11'h123] = 8'h9C;
      chk(ge && !gd, "R6 timeout error, no done", ge, 1);
      chk(ec - we_rise_cyc == T_HLD + int'(tmo) + 1, "R6 error cycle", ec - we_rise_cyc, T_HLD + int'(tmo) + 1);
      @(negedge clk);
      stuck = 0; busy = 0; mem_rdy = 1'b1;
      cfg_timeout = 16'd4000;
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) begin mem[i] = 8'hFF; shadow[i] = 8'hFF; end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en && !done && !err,
          "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n}, 4'hF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en,
          "R1 idle after reset", req_ready, 1);

      do_write(11'h7FF, 8'hA5, 1'b0, 30);
      do_read(11'h7FF, 8'd15, 8'hA5);
      do_write(11'h000, 8'h3C, 1'b1, 25);
      do_read(11'h000, 8'd16, 8'h3C);
      do_write(11'h001, 8'h81, 1'b1, 60);
      do_read(11'h001, 8'd15, 8'h81);
      do_read(11'h001, 8'd0, 8'h7E);   // R7: wait 0 acts as 1, data not yet valid in model
      do_timeout(1'b0, 16'd40);
      do_timeout(1'b1, 16'd50);
      do_read(11'h123, 8'd15, 8'h9C);

      for (int n = 0; n < 40; n++) begin
         logic [AW-1:0] a;
         a = AW'($urandom_range(0, 2047));
         if ($urandom_range(0, 1) == 1)
            do_write(a, 8'($urandom), 1'($urandom_range(0, 1)), int'($urandom_range(20, 120)));
         else
            do_read(a, 8'($urandom_range(15, 20)), shadow[a]);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      fails++;
      $display("FAIL watchdog expired: actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule